// File: doc/BRIEF.md
# OLED controller initialization sequencer

This block brings a monochrome OLED panel controller out of power-up. A single-cycle `start` launches the run. If a reset line is wired to the panel, the block first drives `panel_rst` high for about 4 µs and then holds it low for about 4 µs. It then sends the full configuration command list as a byte stream with a valid/ready handshake. Each byte goes out as its own transfer and is tagged as a command by its control value.

The values inside the stream come from static configuration inputs. These cover panel height, contrast, COM offset, oscillator divider and frequency, precharge phases, COM pin options, VCOMH level, charge-pump need and an optional four-entry lookup table. Three steps of the list appear only when their feature is enabled. A lookup entry outside the usual range raises a warning while it is on the stream, and the entry is still sent. The run finishes with the horizontal addressing mode and display-on. After that, `done` pulses and the block returns to idle.

Top module: `oled_boot_seq`

## Requirements
- R1: While `rst_n` is low and after it is released with no start, `panel_rst`, `tx_valid`, `busy`, `done` and `lut_warn` are all 0.
- R2: With `has_reset_line`=1, `panel_rst` rises the cycle after start is sampled. It stays high for exactly RST_CYC cycles (CLK_HZ/1e6 × RST_US, 500 by default), then stays low for RST_CYC cycles before the first byte is offered. With `has_reset_line`=0, the first byte is offered the cycle after start is sampled and `panel_rst` never rises.
- R3: Every offered byte has `tx_ctrl`=0x80 (command tag). A byte offered without `tx_ready` stays unchanged and valid on the next cycle.
- R4: The base list, in order: 0x81 then contrast; [remap]; COM direction; 0xA8 then height−1; 0xD3 then COM offset; 0xD5 then clock byte; [area]; 0xD9 then precharge; 0xDA then COM pins; 0xDB then VCOMH; 0x8D then pump byte; [LUT]; 0x20, 0x00, 0xAF.
- R5: The segment-remap byte 0xA1 is sent after the contrast value only when `cfg_seg_remap`=1.
- R6: The COM direction byte is 0xC0 with bit 2 set when `cfg_com_invdir`=1. The COM pins option has bit 1 always set, bit 4 set when `cfg_com_seq`=0 and bit 5 set when `cfg_com_lrremap`=1.
- R7: The clock option is (`cfg_clk_div`−1) in bits [3:0] and `cfg_clk_frq` in bits [7:4]. The precharge option is phase 1 in bits [3:0] and phase 2 in bits [7:4].
- R8: 0xD8 and its option are sent only when area colour or low power is enabled. The option is 0x1E if area colour is on, OR 0x05 if low power is on.
- R9: The charge-pump option has bit 4 always set and bit 2 set when `cfg_need_pump`=1.
- R10: When `cfg_lut_en`=1, 0x91 follows the pump option and is followed by the four entries, entry 0 taken from `cfg_lut[7:0]` and entry k from `cfg_lut[8k+7:8k]`. `lut_warn` is high exactly while an entry below 31 or above 63 is offered.
- R11: `done` is high for one cycle, the cycle after 0xAF is accepted. `busy` and `tx_valid` are then 0.
- R12: `start` while busy has no effect: the stream is unchanged and no second run follows `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a run (sampled when idle) |
| has_reset_line | input | 1 | Panel reset line is wired |
| cfg_height | input | 8 | Panel height in rows |
| cfg_contrast | input | 8 | Contrast value |
| cfg_seg_remap | input | 1 | Enable segment remap step |
| cfg_com_invdir | input | 1 | Invert COM scan direction |
| cfg_com_offset | input | 8 | COM display offset |
| cfg_clk_div | input | 5 | Clock divider, 1 to 16 |
| cfg_clk_frq | input | 4 | Oscillator frequency code |
| cfg_area_color | input | 1 | Area colour mode |
| cfg_low_power | input | 1 | Low power mode |
| cfg_pre1 | input | 4 | Precharge phase 1 |
| cfg_pre2 | input | 4 | Precharge phase 2 |
| cfg_com_seq | input | 1 | Sequential COM pin layout |
| cfg_com_lrremap | input | 1 | COM left/right remap |
| cfg_vcomh | input | 8 | VCOMH level |
| cfg_need_pump | input | 1 | Panel needs the internal charge pump |
| cfg_lut_en | input | 1 | Send the lookup table |
| cfg_lut | input | 32 | Four lookup entries, entry 0 in the low byte |
| panel_rst | output | 1 | Active-high panel reset |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Transport accepts the byte |
| tx_byte | output | 8 | Byte value |
| tx_ctrl | output | 8 | Control tag, 0x80 for a command |
| lut_warn | output | 1 | Offered lookup entry out of range |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The panel reset rises one cycle after start is sampled. It is high for RST_CYC cycles and low for RST_CYC cycles, and the first byte follows directly. Without a reset line, the first byte appears one cycle after start. A byte is consumed on the rising edge where valid and ready are both high, and the next byte appears in the cycle that follows. `done` is due one cycle after the edge that takes 0xAF.

The bench drives `tx_ready` and samples every output on falling edges, so each rising edge sees settled values. It predicts a handshake from the ready value it is about to present and compares that byte against a queue built from the configuration. It checks the stall hold one falling edge later and expects `done` exactly one falling edge after the last accepted byte.

// File: rtl/oled_boot_pkg.sv
package oled_boot_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RST_ON  = 2'd1,
        ST_RST_OFF = 2'd2,
        ST_SEND    = 2'd3
    } seq_state_e;

    localparam int STEP_W  = 5;
    localparam int N_STEPS = 28;

    // step indices; order is the order of the stream
    localparam logic [STEP_W-1:0] S_CONTRAST_OP  = 5'd0;
    localparam logic [STEP_W-1:0] S_CONTRAST_VAL = 5'd1;
    localparam logic [STEP_W-1:0] S_REMAP        = 5'd2;
    localparam logic [STEP_W-1:0] S_COMDIR       = 5'd3;
    localparam logic [STEP_W-1:0] S_MUX_OP       = 5'd4;
    localparam logic [STEP_W-1:0] S_MUX_VAL      = 5'd5;
    localparam logic [STEP_W-1:0] S_OFS_OP       = 5'd6;
    localparam logic [STEP_W-1:0] S_OFS_VAL      = 5'd7;
    localparam logic [STEP_W-1:0] S_CLK_OP       = 5'd8;
    localparam logic [STEP_W-1:0] S_CLK_VAL      = 5'd9;
    localparam logic [STEP_W-1:0] S_AREA_OP      = 5'd10;
    localparam logic [STEP_W-1:0] S_AREA_VAL     = 5'd11;
    localparam logic [STEP_W-1:0] S_PRE_OP       = 5'd12;
    localparam logic [STEP_W-1:0] S_PRE_VAL      = 5'd13;
    localparam logic [STEP_W-1:0] S_PINS_OP      = 5'd14;
    localparam logic [STEP_W-1:0] S_PINS_VAL     = 5'd15;
    localparam logic [STEP_W-1:0] S_VCOMH_OP     = 5'd16;
    localparam logic [STEP_W-1:0] S_VCOMH_VAL    = 5'd17;
    localparam logic [STEP_W-1:0] S_PUMP_OP      = 5'd18;
    localparam logic [STEP_W-1:0] S_PUMP_VAL     = 5'd19;
    localparam logic [STEP_W-1:0] S_LUT_OP       = 5'd20;
    localparam logic [STEP_W-1:0] S_LUT0         = 5'd21;
    localparam logic [STEP_W-1:0] S_LUT3         = 5'd24;
    localparam logic [STEP_W-1:0] S_ADDR_OP      = 5'd25;
    localparam logic [STEP_W-1:0] S_ADDR_VAL     = 5'd26;
    localparam logic [STEP_W-1:0] S_DISP_ON      = 5'd27;

    localparam logic [7:0] OP_CONTRAST = 8'h81;
    localparam logic [7:0] OP_REMAP    = 8'hA1;
    localparam logic [7:0] OP_COMDIR   = 8'hC0;
    localparam logic [7:0] OP_MUX      = 8'hA8;
    localparam logic [7:0] OP_OFFSET   = 8'hD3;
    localparam logic [7:0] OP_CLOCK    = 8'hD5;
    localparam logic [7:0] OP_AREA     = 8'hD8;
    localparam logic [7:0] OP_PRECHG   = 8'hD9;
    localparam logic [7:0] OP_PINS     = 8'hDA;
    localparam logic [7:0] OP_VCOMH    = 8'hDB;
    localparam logic [7:0] OP_PUMP     = 8'h8D;
    localparam logic [7:0] OP_LUT      = 8'h91;
    localparam logic [7:0] OP_ADDRMODE = 8'h20;
    localparam logic [7:0] OP_DISP_ON  = 8'hAF;

    localparam logic [7:0] TAG_CMD  = 8'h80;
    localparam logic [7:0] TAG_DATA = 8'h40;

    localparam logic [7:0] LUT_MIN = 8'd31;
    localparam logic [7:0] LUT_MAX = 8'd63;

endpackage

// File: rtl/oled_delay_cnt.sv
module oled_delay_cnt #(
    parameter int LIMIT = 500
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic hit
);
    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_d, cnt_q;

    assign hit = en && (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!en || hit) cnt_d = '0;
        else            cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/oled_cmd_table.sv
module oled_cmd_table
    import oled_boot_pkg::*;
(
    input  logic [STEP_W-1:0] step,
    input  logic [7:0]        cfg_height,
    input  logic [7:0]        cfg_contrast,
    input  logic              cfg_seg_remap,
    input  logic              cfg_com_invdir,
    input  logic [7:0]        cfg_com_offset,
    input  logic [4:0]        cfg_clk_div,
    input  logic [3:0]        cfg_clk_frq,
    input  logic              cfg_area_color,
    input  logic              cfg_low_power,
    input  logic [3:0]        cfg_pre1,
    input  logic [3:0]        cfg_pre2,
    input  logic              cfg_com_seq,
    input  logic              cfg_com_lrremap,
    input  logic [7:0]        cfg_vcomh,
    input  logic              cfg_need_pump,
    input  logic              cfg_lut_en,
    input  logic [31:0]       cfg_lut,
    output logic [7:0]        byte_o,
    output logic              warn_o,
    output logic              last_o,
    output logic [STEP_W-1:0] next_o
);
    logic [4:0]        div_m1;
    logic [STEP_W-1:0] lut_off;
    logic [7:0]        lut_entry;
    logic              is_lut;
    logic              area_any;

    assign div_m1    = cfg_clk_div - 5'd1;
    assign lut_off   = step - S_LUT0;
    assign lut_entry = cfg_lut[{lut_off[1:0], 3'b000} +: 8];
    assign is_lut    = (step >= S_LUT0) && (step <= S_LUT3);
    assign area_any  = cfg_area_color || cfg_low_power;
    assign warn_o    = is_lut && ((lut_entry < LUT_MIN) || (lut_entry > LUT_MAX));
    assign last_o    = (step == S_DISP_ON);

    always_comb begin
        byte_o = 8'h00;
        if (is_lut) begin
            byte_o = lut_entry;
        end else begin
            unique case (step)
                S_CONTRAST_OP:  byte_o = OP_CONTRAST;
                S_CONTRAST_VAL: byte_o = cfg_contrast;
                S_REMAP:        byte_o = OP_REMAP;
                S_COMDIR:       byte_o = OP_COMDIR | {4'h0, 1'b0, cfg_com_invdir, 2'b00};
                S_MUX_OP:       byte_o = OP_MUX;
                S_MUX_VAL:      byte_o = cfg_height - 8'd1;
                S_OFS_OP:       byte_o = OP_OFFSET;
                S_OFS_VAL:      byte_o = cfg_com_offset;
                S_CLK_OP:       byte_o = OP_CLOCK;
                S_CLK_VAL:      byte_o = {cfg_clk_frq, div_m1[3:0]};
                S_AREA_OP:      byte_o = OP_AREA;
                S_AREA_VAL:     byte_o = (cfg_area_color ? 8'h1E : 8'h00) |
                                         (cfg_low_power  ? 8'h05 : 8'h00);
                S_PRE_OP:       byte_o = OP_PRECHG;
                S_PRE_VAL:      byte_o = {cfg_pre2, cfg_pre1};
                S_PINS_OP:      byte_o = OP_PINS;
                S_PINS_VAL:     byte_o = {2'b00, cfg_com_lrremap, ~cfg_com_seq, 4'b0010};
                S_VCOMH_OP:     byte_o = OP_VCOMH;
                S_VCOMH_VAL:    byte_o = cfg_vcomh;
                S_PUMP_OP:      byte_o = OP_PUMP;
                S_PUMP_VAL:     byte_o = {5'b00010, cfg_need_pump, 2'b00};
                S_LUT_OP:       byte_o = OP_LUT;
                S_ADDR_OP:      byte_o = OP_ADDRMODE;
                S_ADDR_VAL:     byte_o = 8'h00;
                S_DISP_ON:      byte_o = OP_DISP_ON;
                default:        byte_o = 8'h00;
            endcase
        end
    end

    // conditional steps are skipped by jumping over them
    always_comb begin
        next_o = step + STEP_W'(1);
        if (step == S_CONTRAST_VAL && !cfg_seg_remap) next_o = S_COMDIR;
        if (step == S_CLK_VAL && !area_any)           next_o = S_PRE_OP;
        if (step == S_PUMP_VAL && !cfg_lut_en)        next_o = S_ADDR_OP;
    end
endmodule

// File: rtl/oled_boot_seq.sv
module oled_boot_seq
    import oled_boot_pkg::*;
#(
    parameter int CLK_HZ = 125_000_000,
    parameter int RST_US = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        has_reset_line,
    input  logic [7:0]  cfg_height,
    input  logic [7:0]  cfg_contrast,
    input  logic        cfg_seg_remap,
    input  logic        cfg_com_invdir,
    input  logic [7:0]  cfg_com_offset,
    input  logic [4:0]  cfg_clk_div,
    input  logic [3:0]  cfg_clk_frq,
    input  logic        cfg_area_color,
    input  logic        cfg_low_power,
    input  logic [3:0]  cfg_pre1,
    input  logic [3:0]  cfg_pre2,
    input  logic        cfg_com_seq,
    input  logic        cfg_com_lrremap,
    input  logic [7:0]  cfg_vcomh,
    input  logic        cfg_need_pump,
    input  logic        cfg_lut_en,
    input  logic [31:0] cfg_lut,
    output logic        panel_rst,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [7:0]  tx_byte,
    output logic [7:0]  tx_ctrl,
    output logic        lut_warn,
    output logic        busy,
    output logic        done
);
    localparam int RST_CYC = (CLK_HZ / 1_000_000) * RST_US;

    typedef struct packed {
        seq_state_e        state;
        logic [STEP_W-1:0] step;
        logic              done;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic              cnt_en, cnt_hit;
    logic [7:0]        step_byte;
    logic              step_warn, step_last;
    logic [STEP_W-1:0] step_next;

    assign cnt_en = (r_q.state == ST_RST_ON) || (r_q.state == ST_RST_OFF);

    oled_delay_cnt #(.LIMIT(RST_CYC)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .hit   (cnt_hit)
    );

    oled_cmd_table u_table (
        .step            (r_q.step),
        .cfg_height      (cfg_height),
        .cfg_contrast    (cfg_contrast),
        .cfg_seg_remap   (cfg_seg_remap),
        .cfg_com_invdir  (cfg_com_invdir),
        .cfg_com_offset  (cfg_com_offset),
        .cfg_clk_div     (cfg_clk_div),
        .cfg_clk_frq     (cfg_clk_frq),
        .cfg_area_color  (cfg_area_color),
        .cfg_low_power   (cfg_low_power),
        .cfg_pre1        (cfg_pre1),
        .cfg_pre2        (cfg_pre2),
        .cfg_com_seq     (cfg_com_seq),
        .cfg_com_lrremap (cfg_com_lrremap),
        .cfg_vcomh       (cfg_vcomh),
        .cfg_need_pump   (cfg_need_pump),
        .cfg_lut_en      (cfg_lut_en),
        .cfg_lut         (cfg_lut),
        .byte_o          (step_byte),
        .warn_o          (step_warn),
        .last_o          (step_last),
        .next_o          (step_next)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.step  = S_CONTRAST_OP;
                    r_d.state = has_reset_line ? ST_RST_ON : ST_SEND;
                end
            end
            ST_RST_ON:  if (cnt_hit) r_d.state = ST_RST_OFF;
            ST_RST_OFF: if (cnt_hit) r_d.state = ST_SEND;
            ST_SEND: begin
                if (tx_ready) begin
                    if (step_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.step = step_next;
                    end
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, step: '0, done: 1'b0};
        else        r_q <= r_d;
    end

    assign panel_rst = (r_q.state == ST_RST_ON);
    assign tx_valid  = (r_q.state == ST_SEND);
    assign tx_byte   = tx_valid ? step_byte : 8'h00;
    assign tx_ctrl   = tx_valid ? TAG_CMD : 8'h00;
    assign lut_warn  = tx_valid && step_warn;
    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;

    // R3: an offered byte is held until accepted
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));

    // R11: done follows acceptance of display-on
    a_r11_done_src: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(tx_valid && tx_ready && tx_byte == OP_DISP_ON));

    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: block is idle when done is raised
    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy && !tx_valid);

    // R10: warning only with an offered byte
    a_r10_warn_valid: assert property (@(posedge clk) disable iff (!rst_n)
        lut_warn |-> tx_valid);

    // R2: reset pulse ends into the quiet phase, never straight into data
    a_r2_rst_to_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(panel_rst) |-> !tx_valid && busy);
endmodule

// File: tb/oled_boot_seq_tb.sv
module oled_boot_seq_tb;
    localparam int RST_CYC = 500;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        has_reset_line = 1'b1;
    logic [7:0]  cfg_height = 8'd16;
    logic [7:0]  cfg_contrast = 8'd127;
    logic        cfg_seg_remap = 1'b1;
    logic        cfg_com_invdir = 1'b0;
    logic [7:0]  cfg_com_offset = 8'd0;
    logic [4:0]  cfg_clk_div = 5'd1;
    logic [3:0]  cfg_clk_frq = 4'd8;
    logic        cfg_area_color = 1'b0;
    logic        cfg_low_power = 1'b0;
    logic [3:0]  cfg_pre1 = 4'd2;
    logic [3:0]  cfg_pre2 = 4'd2;
    logic        cfg_com_seq = 1'b0;
    logic        cfg_com_lrremap = 1'b0;
    logic [7:0]  cfg_vcomh = 8'h20;
    logic        cfg_need_pump = 1'b1;
    logic        cfg_lut_en = 1'b0;
    logic [31:0] cfg_lut = 32'h0;
    logic        panel_rst, tx_valid, tx_ready, lut_warn, busy, done;
    logic [7:0]  tx_byte, tx_ctrl;

    always #4 clk = ~clk;

    oled_boot_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .has_reset_line(has_reset_line),
        .cfg_height(cfg_height), .cfg_contrast(cfg_contrast),
        .cfg_seg_remap(cfg_seg_remap), .cfg_com_invdir(cfg_com_invdir),
        .cfg_com_offset(cfg_com_offset), .cfg_clk_div(cfg_clk_div),
        .cfg_clk_frq(cfg_clk_frq), .cfg_area_color(cfg_area_color),
        .cfg_low_power(cfg_low_power), .cfg_pre1(cfg_pre1), .cfg_pre2(cfg_pre2),
        .cfg_com_seq(cfg_com_seq), .cfg_com_lrremap(cfg_com_lrremap),
        .cfg_vcomh(cfg_vcomh), .cfg_need_pump(cfg_need_pump),
        .cfg_lut_en(cfg_lut_en), .cfg_lut(cfg_lut),
        .panel_rst(panel_rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_byte(tx_byte), .tx_ctrl(tx_ctrl), .lut_warn(lut_warn),
        .busy(busy), .done(done)
    );

    int n_checks = 0;
    int n_fails  = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    int  rmode = 0;
    int  done_cnt = 0;
    bit  finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b, input bit w, input string tag);
        exp_q.push_back({w, b});
        tag_q.push_back(tag);
    endtask

    // expected stream from the requirements
    task automatic build();
        logic [4:0] dm1;
        exp_q.delete(); tag_q.delete();
        push(8'h81, 0, "R4 contrast op"); push(cfg_contrast, 0, "R4 contrast");
        if (cfg_seg_remap) push(8'hA1, 0, "R5 remap");
        push(cfg_com_invdir ? 8'hC4 : 8'hC0, 0, "R6 comdir");
        push(8'hA8, 0, "R4 mux op"); push(cfg_height - 8'd1, 0, "R4 mux");
        push(8'hD3, 0, "R4 offset op"); push(cfg_com_offset, 0, "R4 offset");
        dm1 = cfg_clk_div - 5'd1;
        push(8'hD5, 0, "R4 clock op"); push({cfg_clk_frq, dm1[3:0]}, 0, "R7 clock");
        if (cfg_area_color || cfg_low_power) begin
            push(8'hD8, 0, "R8 area op");
            push((cfg_area_color ? 8'h1E : 8'h00) | (cfg_low_power ? 8'h05 : 8'h00), 0, "R8 area");
        end
        push(8'hD9, 0, "R4 prechg op"); push({cfg_pre2, cfg_pre1}, 0, "R7 prechg");
        push(8'hDA, 0, "R4 pins op");
        push(8'h02 | (cfg_com_seq ? 8'h00 : 8'h10) | (cfg_com_lrremap ? 8'h20 : 8'h00), 0, "R6 pins");
        push(8'hDB, 0, "R4 vcomh op"); push(cfg_vcomh, 0, "R4 vcomh");
        push(8'h8D, 0, "R4 pump op"); push(cfg_need_pump ? 8'h14 : 8'h10, 0, "R9 pump");
        if (cfg_lut_en) begin
            push(8'h91, 0, "R10 lut op");
            for (int k = 0; k < 4; k++) begin
                logic [7:0] e;
                e = cfg_lut[8*k +: 8];
                push(e, (e < 8'd31) || (e > 8'd63), "R10 lut entry");
            end
        end
        push(8'h20, 0, "R4 addr op"); push(8'h00, 0, "R4 addr");
        push(8'hAF, 0, "R11 disp on");
    endtask

    // monitor: drives ready and scores each handshake
    initial begin
        logic [7:0] lfsr = 8'h5A;
        bit pend_done = 0, held = 0;
        logic [7:0] held_b = 8'h00;
        tx_ready = 1'b0;
        forever begin
            bit r;
            @(negedge clk);
            r = (rmode == 0) ? 1'b1 : lfsr[0];
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            if (rst_n) begin
                if (pend_done) begin
                    chk(done == 1'b1, "R11 done pulse", done, 1);
                    chk(!busy && !tx_valid, "R11 idle after done", {busy, tx_valid}, 0);
                    pend_done = 0;
                    done_cnt++;
                end else if (done) begin
                    chk(0, "R11 unexpected done", done, 0);
                end
                if (held) begin
                    chk(tx_valid && tx_byte == held_b, "R3 hold under stall", tx_byte, held_b);
                    held = 0;
                end
                if (tx_valid) begin
                    if (tx_ctrl != 8'h80) chk(0, "R3 ctrl tag", tx_ctrl, 8'h80);
                    if (r) begin
                        if (exp_q.size() == 0) begin
                            chk(0, "R12 extra byte", tx_byte, 0);
                        end else begin
                            logic [8:0] e;
                            string t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            chk(tx_byte == e[7:0], t, tx_byte, e[7:0]);
                            chk(lut_warn == e[8], {t, " warn (R10)"}, lut_warn, e[8]);
                            if (exp_q.size() == 0) pend_done = 1;
                        end
                    end else begin
                        held = 1; held_b = tx_byte;
                    end
                end
            end
            tx_ready = r;
        end
    end

    task automatic run(input bit rl, input bit mid_start);
        int hi = 0, lo = 0, d0;
        has_reset_line = rl;
        build();
        d0 = done_cnt;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        while (!tx_valid && hi + lo < 4 * RST_CYC) begin
            if (panel_rst) hi++; else lo++;
            @(negedge clk);
        end
        chk(hi == (rl ? RST_CYC : 0), "R2 reset high length", hi, rl ? RST_CYC : 0);
        chk(lo == (rl ? RST_CYC : 0), "R2 reset low gap", lo, rl ? RST_CYC : 0);
        if (mid_start) begin
            repeat (5) @(negedge clk);
            start = 1'b1;   // R12: ignored while busy
            @(negedge clk); start = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(!busy && !tx_valid && !panel_rst, "R12 no second run", {busy, tx_valid, panel_rst}, 0);
        chk(exp_q.size() == 0, "R4 stream complete", exp_q.size(), 0);
        chk(done_cnt == d0 + 1, "R11 single done", done_cnt - d0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!panel_rst && !tx_valid && !busy && !done && !lut_warn, "R1 in reset",
            {panel_rst, tx_valid, busy, done, lut_warn}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!panel_rst && !tx_valid && !busy && !done && !lut_warn, "R1 after reset",
            {panel_rst, tx_valid, busy, done, lut_warn}, 0);

        // defaults with reset line, always ready
        rmode = 0;
        run(1'b1, 1'b0);

        // no reset line, all options flipped, LUT with out-of-range entries, stalls
        rmode = 1;
        cfg_seg_remap = 0; cfg_com_invdir = 1; cfg_area_color = 1; cfg_low_power = 1;
        cfg_com_seq = 1; cfg_com_lrremap = 1; cfg_need_pump = 0; cfg_com_offset = 8'd7;
        cfg_pre1 = 4'd3; cfg_pre2 = 4'd9; cfg_lut_en = 1;
        cfg_lut = {8'd64, 8'd63, 8'd31, 8'd30};
        run(1'b0, 1'b1);

        // low power only, extreme clock fields, in-range LUT
        cfg_area_color = 0; cfg_low_power = 1; cfg_clk_div = 5'd16; cfg_clk_frq = 4'hF;
        cfg_height = 8'd64; cfg_contrast = 8'd255; cfg_seg_remap = 1;
        cfg_lut = {8'd40, 8'd50, 8'd33, 8'd62};
        run(1'b1, 1'b1);

        // area colour only, no LUT
        rmode = 0;
        cfg_area_color = 1; cfg_low_power = 0; cfg_lut_en = 0; cfg_vcomh = 8'h40;
        run(1'b0, 1'b0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule